// File: doc/BRIEF.md
# Descriptor-Chain Transmit Sequencer

This block moves frames from memory onto a stream by following a linked chain of descriptors. Each descriptor names a buffer, a byte count and frame boundary flags. For each descriptor the sequencer reads the descriptor, sends its five side-band words on a control stream when the descriptor opens a frame, and then reads the buffer one 32-bit word at a time onto a data stream. It writes a completion status back into the descriptor, moves to the next pointer, and stops at the tail descriptor.

Software-facing register decoding and interrupt logic sit outside this block. The enclosing logic loads the current pointer, presents the tail pointer, holds `run` high, and pulses `kick` to start a walk. The block reports `busy`, `halted`, `idle` and a one-cycle `pkt_done` per finished frame.

Memory is reached through a single-outstanding word master. `mem_req` and its address, write enable and write data stay steady until `mem_ack`, and read data is valid in the `mem_ack` cycle. Both stream outputs follow valid/ready rules. A beat transfers on a cycle where valid and ready are both high. Once valid is high, the payload stays unchanged until that transfer, so back-pressure only stalls the sequencer: the next buffer read waits, and nothing is lost.

Top module: `sgtx_seq`

## Requirements
- R1: After reset, `halted`=1, `idle`=0, `busy`=0, and `mem_req`, `c_valid`, `d_valid` and `pkt_done` are all 0.
- R2: While `run` is 0, a `kick` pulse has no effect: `busy` stays 0, no memory request is issued and `halted`/`idle` keep their values.
- R3: A descriptor at address A is little-endian 32-bit words. The next pointer is at A+0x00, the buffer address at A+0x08, the control word at A+0x18, the status word at A+0x1C, and five side-band words at A+0x20..A+0x30. Only the low 32 bits of the pointers are read.
- R4: Control word fields: bits 22:0 give the byte length, bit 26 flags end of frame, and bit 27 flags start of frame.
- R5: If the fetched status word has bit 31 set, the sequencer sets `halted`, ends the walk with `cur_ptr` unchanged, emits no stream beat and performs no memory write.
- R6: For a start-of-frame descriptor, the five side-band words go out on the control stream in address order, and all are accepted before the first buffer word is read.
- R7: A descriptor of length L gives ceil(L/4) data beats. Beat i carries the word at buffer+4i. `d_keep` bit b is set when more than b bytes of the descriptor remain at that beat. A length of 0 gives no beats.
- R8: `d_last` is set only on the final beat of an end-of-frame descriptor. Each end-of-frame descriptor gives exactly one `pkt_done` pulse.
- R9: After a descriptor's buffer, the word L | 0x8000_0000 is written to A+0x1C.
- R10: After write-back, `cur_ptr` takes the next pointer. If A equals `tail_ptr`, `idle` is set and the walk ends; otherwise the next descriptor is fetched.
- R11: While valid is high and ready is low on either stream, valid and the payload stay unchanged, and no beat is dropped or repeated.
- R12: `cur_load` copies `cur_in` to `cur_ptr` while the block is not busy; a `kick` with `run` high clears `halted` and `idle` and starts the walk at `cur_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables walking |
| kick | input | 1 | Start pulse (tail updated) |
| cur_load | input | 1 | Load current pointer |
| cur_in | input | ADDR_W | Current pointer load value |
| tail_ptr | input | ADDR_W | Address of last descriptor to process |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| busy | output | 1 | Walk in progress |
| halted | output | 1 | Stopped on an already-complete descriptor |
| idle | output | 1 | Stopped after the tail descriptor |
| pkt_done | output | 1 | One-cycle pulse per end-of-frame descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done; read data valid |
| mem_rdata | input | 32 | Read data |
| c_valid | output | 1 | Control stream valid |
| c_ready | input | 1 | Control stream ready |
| c_data | output | 32 | Side-band word |
| d_valid | output | 1 | Data stream valid |
| d_ready | input | 1 | Data stream ready |
| d_data | output | 32 | Buffer word |
| d_keep | output | 4 | Valid bytes of the beat |
| d_last | output | 1 | Final beat of a frame |

## Verification
A directed chain first mixes a frame spread over two descriptors with partial final words and a one-word frame. The same chain is then walked again into a descriptor it has already completed, which separates the halt path from the tail path. Further checks cover a zero-length end-of-frame descriptor and a `kick` with `run` low. Random chains with random lengths, flags and stall patterns on both stream ready inputs then test the keep masks, last placement, side-band ordering and status write-back under back-pressure.

// File: rtl/sgtx_pkg.sv
package sgtx_pkg;
  localparam int WORD_W    = 32;
  localparam int KEEP_W    = WORD_W / 8;
  localparam int LEN_W     = 23;
  localparam int EOF_BIT   = 26;
  localparam int SOF_BIT   = 27;
  localparam int DONE_BIT  = 31;
  localparam int APP_WORDS = 5;
  localparam logic [7:0] OFF_NEXT = 8'h00;
  localparam logic [7:0] OFF_BUF  = 8'h08;
  localparam logic [7:0] OFF_CTRL = 8'h18;
  localparam logic [7:0] OFF_STAT = 8'h1C;
  localparam logic [7:0] OFF_APP  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DESC, ST_APP, ST_DATA, ST_WB, ST_NEXT
  } sgtx_state_e;

  function automatic logic [7:0] desc_word_off(input logic [2:0] idx);
    case (idx[1:0])
      2'd0:    return OFF_NEXT;
      2'd1:    return OFF_BUF;
      2'd2:    return OFF_CTRL;
      default: return OFF_STAT;
    endcase
  endfunction
endpackage

// File: rtl/sgtx_keep.sv
module sgtx_keep
  import sgtx_pkg::*;
(
  input  logic [LEN_W-1:0]  rem,
  output logic [KEEP_W-1:0] keep,
  output logic              final_beat
);
  for (genvar b = 0; b < KEEP_W; b++) begin : g_byte
    assign keep[b] = (rem > LEN_W'(b));
  end
  assign final_beat = (rem <= LEN_W'(KEEP_W));
endmodule

// File: rtl/sgtx_hold.sv
module sgtx_hold #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sgtx_seq.sv
module sgtx_seq
  import sgtx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              kick,
  input  logic              cur_load,
  input  logic [ADDR_W-1:0] cur_in,
  input  logic [ADDR_W-1:0] tail_ptr,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic              busy,
  output logic              halted,
  output logic              idle,
  output logic              pkt_done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              c_valid,
  input  logic              c_ready,
  output logic [31:0]       c_data,
  output logic              d_valid,
  input  logic              d_ready,
  output logic [31:0]       d_data,
  output logic [3:0]        d_keep,
  output logic              d_last
);
  localparam int DPAY_W = WORD_W + KEEP_W + 1;

  sgtx_state_e       state;
  logic [2:0]        widx;
  logic [ADDR_W-1:0] nxt_ptr, buf_ptr, rd_ptr;
  logic [31:0]       ctrl;
  logic [LEN_W-1:0]  rem;
  logic [KEEP_W-1:0] beat_keep;
  logic              beat_final;
  logic              c_load, d_load;
  logic [DPAY_W-1:0] d_pay_in, d_pay_out;
  logic              rd_ack;

  sgtx_keep u_keep (.rem(rem), .keep(beat_keep), .final_beat(beat_final));

  assign rd_ack   = mem_ack && !mem_we;
  assign c_load   = (state == ST_APP) && rd_ack;
  assign d_load   = (state == ST_DATA) && rd_ack;
  assign d_pay_in = {ctrl[EOF_BIT] && beat_final, beat_keep, mem_rdata};

  sgtx_hold #(.W(WORD_W)) u_chold (
    .clk(clk), .rst_n(rst_n), .load(c_load), .load_data(mem_rdata),
    .out_valid(c_valid), .out_ready(c_ready), .out_data(c_data)
  );

  sgtx_hold #(.W(DPAY_W)) u_dhold (
    .clk(clk), .rst_n(rst_n), .load(d_load), .load_data(d_pay_in),
    .out_valid(d_valid), .out_ready(d_ready), .out_data(d_pay_out)
  );

  assign {d_last, d_keep, d_data} = d_pay_out;
  assign busy = (state != ST_IDLE);

  // Memory request decode
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_ptr;
    mem_wdata = '0;
    case (state)
      ST_DESC: begin
        mem_req  = 1'b1;
        mem_addr = cur_ptr + ADDR_W'(desc_word_off(widx));
      end
      ST_APP: begin
        mem_req  = !c_valid;
        mem_addr = cur_ptr + ADDR_W'(OFF_APP) + ADDR_W'({widx, 2'b00});
      end
      ST_DATA: begin
        mem_req  = !c_valid && !d_valid;
        mem_addr = rd_ptr;
      end
      ST_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_ptr + ADDR_W'(OFF_STAT);
        mem_wdata = {1'b1, {(31-LEN_W){1'b0}}, ctrl[LEN_W-1:0]};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      widx     <= '0;
      cur_ptr  <= '0;
      nxt_ptr  <= '0;
      buf_ptr  <= '0;
      rd_ptr   <= '0;
      ctrl     <= '0;
      rem      <= '0;
      halted   <= 1'b1;
      idle     <= 1'b0;
      pkt_done <= 1'b0;
    end else begin
      pkt_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cur_load) cur_ptr <= cur_in;
          if (kick && run) begin
            halted <= 1'b0;
            idle   <= 1'b0;
            widx   <= '0;
            state  <= ST_DESC;
          end
        end
        ST_DESC: if (mem_ack) begin
          widx <= widx + 3'd1;
          case (widx[1:0])
            2'd0: nxt_ptr <= mem_rdata[ADDR_W-1:0];
            2'd1: buf_ptr <= mem_rdata[ADDR_W-1:0];
            2'd2: ctrl    <= mem_rdata;
            default: begin
              widx   <= '0;
              rem    <= ctrl[LEN_W-1:0];
              rd_ptr <= buf_ptr;
              if (mem_rdata[DONE_BIT]) begin
                halted <= 1'b1;
                state  <= ST_IDLE;
              end else if (ctrl[SOF_BIT]) begin
                state <= ST_APP;
              end else begin
                state <= (ctrl[LEN_W-1:0] == '0) ? ST_WB : ST_DATA;
              end
            end
          endcase
        end
        ST_APP: if (mem_ack) begin
          widx <= widx + 3'd1;
          if (widx == 3'(APP_WORDS - 1)) begin
            state <= (rem == '0) ? ST_WB : ST_DATA;
          end
        end
        ST_DATA: if (mem_ack) begin
          rd_ptr <= rd_ptr + ADDR_W'(KEEP_W);
          rem    <= beat_final ? '0 : rem - LEN_W'(KEEP_W);
          if (beat_final) state <= ST_WB;
        end
        ST_WB: if (mem_ack) begin
          pkt_done <= ctrl[EOF_BIT];
          state    <= ST_NEXT;
        end
        ST_NEXT: begin
          cur_ptr <= nxt_ptr;
          widx    <= '0;
          if (cur_ptr == tail_ptr) begin
            idle  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= run ? ST_DESC : ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgtx_seq_chk.sv
module sgtx_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        halted,
  input logic        idle,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        c_valid,
  input logic        c_ready,
  input logic [31:0] c_data,
  input logic        d_valid,
  input logic        d_ready,
  input logic [31:0] d_data,
  input logic [3:0]  d_keep,
  input logic        d_last
);
  p_dstall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid && !d_ready |=> d_valid && $stable(d_data) && $stable(d_keep) && $stable(d_last));

  p_cstall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    c_valid && !c_ready |=> c_valid && $stable(c_data));

  p_wb_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[31] && (mem_wdata[30:23] == 8'd0));

  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(idle && halted));

  p_keep_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    d_valid |-> (d_keep == 4'h1 || d_keep == 4'h3 || d_keep == 4'h7 || d_keep == 4'hF));
endmodule

bind sgtx_seq sgtx_seq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sgtx_seq_bench.sv
module sgtx_seq_bench;
  localparam int AW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic run = 0, kick = 0, cur_load = 0;
  logic [AW-1:0] cur_in = 0, tail_ptr = 0, cur_ptr;
  logic busy, halted, idle, pkt_done;
  logic mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic c_valid, c_ready, d_valid, d_ready, d_last;
  logic [31:0] c_data, d_data;
  logic [3:0] d_keep;

  sgtx_seq #(.ADDR_W(AW)) u_sgtx_seq (.*);

  always #10 clk = ~clk;

  int checks = 0, errs = 0, cyc = 0, wr_cnt = 0, req_cnt = 0, pkt_cnt = 0, exp_pkts = 0;
  bit rnd_ready = 0;
  logic [31:0] mem [0:1023];
  logic [36:0] exp_d[$];
  logic [31:0] exp_c[$];
  int st_slot[$];
  logic [31:0] st_val[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, one-cycle ack
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      req_cnt++;
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        wr_cnt++;
      end else mem_rdata <= mem[mem_addr[11:2]];
    end else mem_ack <= 1'b0;
  end

  always @(posedge clk) begin
    #2;
    d_ready = rnd_ready ? (($urandom % 4) != 0) : 1'b1;
    c_ready = rnd_ready ? (($urandom % 3) != 0) : 1'b1;
  end

  // stream monitors, sampled mid-cycle
  always @(negedge clk) if (rst_n) begin
    if (d_valid && d_ready) begin
      if (exp_d.size() == 0) chk(0, "R7 unexpected data beat", {d_last, d_keep, d_data}, 0);
      else begin
        logic [36:0] e;
        e = exp_d.pop_front();
        chk({d_last, d_keep, d_data} == e, "R7/R8/R11 data beat", {d_last, d_keep, d_data}, e);
      end
    end
    if (c_valid && c_ready) begin
      if (exp_c.size() == 0) chk(0, "R6 unexpected side-band word", c_data, 0);
      else begin
        logic [31:0] e;
        e = exp_c.pop_front();
        chk(c_data == e, "R6 side-band word", c_data, e);
      end
    end
    if (pkt_done) pkt_cnt++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  function automatic logic [3:0] kmask(input int r);
    return (r >= 4) ? 4'hF : 4'((1 << r) - 1);
  endfunction

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // slot k: descriptor at 128k, buffer at 2048+64k
  task automatic add_desc(input int slot, input int nslot, input int len,
                          input bit sof, input bit eof, input bit done);
    int b, bb;
    b  = slot * 32;
    bb = 512 + slot * 16;
    mem[b] = nslot * 128; mem[b+1] = 0; mem[b+2] = bb * 4; mem[b+3] = 0;
    mem[b+4] = 0; mem[b+5] = 0;
    mem[b+6] = 32'(len) | (32'(eof) << 26) | (32'(sof) << 27);
    mem[b+7] = done ? 32'h8000_0000 : 32'h0;
    for (int k = 0; k < 5; k++) mem[b+8+k] = $urandom;
    if (!done) begin
      if (sof) for (int k = 0; k < 5; k++) exp_c.push_back(mem[b+8+k]);
      for (int w = 0; w*4 < len; w++) begin
        mem[bb+w] = $urandom;
        exp_d.push_back({eof && (len - 4*w <= 4), kmask(len - 4*w), mem[bb+w]});
      end
      if (eof) exp_pkts++;
      st_slot.push_back(slot);
      st_val.push_back(32'(len) | 32'h8000_0000);
    end
  endtask

  task automatic walk(input int first, input int last);
    int g;
    cur_in = first * 128; cur_load = 1; tick(); cur_load = 0;
    tail_ptr = last * 128;
    kick = 1; tick(); kick = 0;
    g = 0;
    tick(2);
    while ((busy || d_valid || c_valid) && g < 20000) begin tick(); g++; end
    tick(2);
  endtask

  task automatic check_walk(input string tag);
    chk(exp_d.size() == 0, "R7 all data beats delivered", exp_d.size(), 0);
    chk(exp_c.size() == 0, "R6 all side-band words delivered", exp_c.size(), 0);
    chk(pkt_cnt == exp_pkts, "R8 pkt_done count", pkt_cnt, exp_pkts);
    while (st_slot.size() > 0) begin
      int s;
      logic [31:0] v;
      s = st_slot.pop_front();
      v = st_val.pop_front();
      chk(mem[s*32+7] == v, "R9 status write-back", mem[s*32+7], v);
    end
  endtask

  initial begin
    int rs, n, base;
    rs = $urandom(32'd2024);
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    d_ready = 1; c_ready = 1;
    tick(3);
    // R1 reset state
    chk(halted && !idle && !busy, "R1 reset flags", {halted, idle, busy}, 3'b100);
    chk(!mem_req && !c_valid && !d_valid && !pkt_done, "R1 reset outputs",
        {mem_req, c_valid, d_valid, pkt_done}, 0);
    rst_n = 1; tick(2);
    chk(halted && !idle && !busy, "R1 flags after release", {halted, idle, busy}, 3'b100);

    // R2 kick without run
    add_desc(0, 1, 8, 1, 1, 0);
    exp_d.delete(); exp_c.delete(); st_slot.delete(); st_val.delete(); exp_pkts = 0;
    cur_in = 0; cur_load = 1; tick(); cur_load = 0; tail_ptr = 0;
    kick = 1; tick(); kick = 0; tick(10);
    chk(!busy && req_cnt == 0, "R2 kick ignored with run low", req_cnt, 0);
    chk(halted && !idle, "R2 flags unchanged", {halted, idle}, 2'b10);

    // R3/R4/R6/R7/R8/R9/R10 directed chain: two-descriptor frame then one-word frame
    run = 1;
    add_desc(0, 1, 10, 1, 0, 0);
    add_desc(1, 2, 7, 0, 1, 0);
    add_desc(2, 0, 4, 1, 1, 0);
    walk(0, 2);
    check_walk("directed");
    chk(idle && !halted, "R10 idle at tail", {idle, halted}, 2'b10);
    chk(cur_ptr == 0, "R10 cur_ptr follows next of tail", cur_ptr, 0);

    // R5 walk into an already-complete descriptor (slot 0 now complete)
    n = wr_cnt;
    tail_ptr = 5 * 128;
    kick = 1; tick(); kick = 0; tick(2);
    while (busy) tick();
    tick(2);
    chk(halted && !idle, "R5 halted on complete descriptor", {halted, idle}, 2'b10);
    chk(wr_cnt == n, "R5 no write on halt", wr_cnt, n);
    chk(cur_ptr == 0, "R5 cur_ptr unchanged on halt", cur_ptr, 0);
    chk(exp_d.size() == 0 && pkt_cnt == exp_pkts, "R5 no beats on halt", pkt_cnt, exp_pkts);

    // R4/R7 zero-length end-of-frame descriptor, with R12 reload
    add_desc(3, 4, 0, 0, 1, 0);
    add_desc(4, 9, 3, 0, 1, 0);
    walk(3, 4);
    check_walk("zero");
    chk(cur_ptr == 9 * 128, "R12 reload and walk from cur_in", cur_ptr, 9*128);

    // R11 random chains with back-pressure
    rnd_ready = 1;
    for (int r = 0; r < 12; r++) begin
      n = 1 + ($urandom % 4);
      base = (r % 3) * 5;
      for (int k = 0; k < n; k++)
        add_desc(base + k, (k == n-1) ? 15 : base + k + 1, $urandom % 21,
                 ($urandom % 2) == 1, ($urandom % 2) == 1, 0);
      walk(base, base + n - 1);
      check_walk("random");
      chk(idle && cur_ptr == 15 * 128, "R10 random tail stop", cur_ptr, 15*128);
    end
    rnd_ready = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule